// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block links two 8-bit buses, called A and B, in both directions. Each direction has its own capture register with its own clock, its own source select and its own drive enable. For each direction, the select picks either the value currently on the source bus or the value held in that direction's capture register. The picked value leaves the block bit-inverted.

Capture never depends on the select or enable controls. A rising edge on a direction's clock always samples its source bus. This lets a system snapshot one bus while driving the other, or store both buses on the same edge. Tri-state pins are not used. Each side has an 8-bit data vector and a 1-bit drive flag, and the data vector reads as zero whenever its side is not driven.

Top module: `regxcvr`

## Requirements
- R1: While `rst` is high, a rising edge of `clk_ab` clears the A-to-B register and a rising edge of `clk_ba` clears the B-to-A register. Each register is cleared only on its own clock.
- R2: When `rst` is low, a rising edge of `clk_ab` loads `a_in` into the A-to-B register.
- R3: When `rst` is low, a rising edge of `clk_ba` loads `b_in` into the B-to-A register.
- R4: Register capture happens whatever the values of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`, including when both sides are undriven.
- R5: With `sel_ab` = 0 and the B side driven, `b_out` equals the bitwise complement of `a_in`.
- R6: With `sel_ab` = 1 and the B side driven, `b_out` equals the bitwise complement of the A-to-B register.
- R7: With the A side driven, `a_out` equals the complement of `b_in` when `sel_ba` = 0, and the complement of the B-to-A register when `sel_ba` = 1.
- R8: `b_drive` is high exactly when `oe_ab` = 1 (active high). `a_drive` is high exactly when `oe_ba_n` = 0 (active low).
- R9: When a side's drive flag is low, its data vector is all zeros.
- R10: Edges on both clocks in the same cycle capture both buses at once.
- R11: Driving both sides at once with both selects at 0 is an illegal input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled by each register on its own clock |
| a_in | input | 8 | Value currently on the A bus |
| b_in | input | 8 | Value currently on the B bus |
| sel_ab | input | 1 | B-side source: 0 live A bus, 1 stored register |
| sel_ba | input | 1 | A-side source: 0 live B bus, 1 stored register |
| oe_ab | input | 1 | Drive B side, active high |
| oe_ba_n | input | 1 | Drive A side, active low |
| b_out | output | 8 | Inverted data for the B bus, zero when undriven |
| b_drive | output | 1 | B-side driver enable |
| a_out | output | 8 | Inverted data for the A bus, zero when undriven |
| a_drive | output | 1 | A-side driver enable |

## Verification
The assertions assume the inputs never drive both sides with both selects at live data, because on a real bus that setup closes a loop through two inverters. They also assume the buses and controls stay steady around each capture edge. The stimulus changes inputs only while both capture clocks are low. Every table row and directed step is checked for legality, and the loop combination is never applied.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

    localparam int XCVR_BUS_W = 8;
    localparam int XCVR_DIRS  = 2;

    typedef enum logic [0:0] {
        DIR_A2B = 1'b0,
        DIR_B2A = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic use_stored;
        logic drive;
    } path_ctrl_t;

    // Turns a raw enable pin into an active-high drive level.
    function automatic logic drive_level(input logic pin, input logic active_low);
        return active_low ? ~pin : pin;
    endfunction

    function automatic path_ctrl_t make_ctrl(input logic sel, input logic pin,
                                             input logic active_low);
        path_ctrl_t c;
        c.use_stored = sel;
        c.drive      = drive_level(pin, active_low);
        return c;
    endfunction

endpackage

// File: rtl/regxcvr_store.sv
module regxcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R2 R3 R4
    capture_follows_bus_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/regxcvr_path.sv
module regxcvr_path
    import regxcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  path_ctrl_t   ctl,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] data_o,
    output logic         drive_o
);

    logic [W-1:0] picked;

    always_comb begin
        picked  = ctl.use_stored ? stored : live;
        drive_o = ctl.drive;
        data_o  = ctl.drive ? ~picked : '0;
    end

endmodule

// File: rtl/regxcvr.sv
module regxcvr
    import regxcvr_pkg::*;
#(
    parameter int W = XCVR_BUS_W
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive
);

    localparam int N = XCVR_DIRS;

    logic         cap_clk [N];
    logic [W-1:0] src     [N];
    logic [W-1:0] held    [N];
    logic [W-1:0] dout    [N];
    logic         dflag   [N];
    path_ctrl_t   ctl     [N];

    always_comb begin
        cap_clk[DIR_A2B] = clk_ab;
        cap_clk[DIR_B2A] = clk_ba;
        src[DIR_A2B]     = a_in;
        src[DIR_B2A]     = b_in;
        ctl[DIR_A2B]     = make_ctrl(sel_ab, oe_ab, 1'b0);
        ctl[DIR_B2A]     = make_ctrl(sel_ba, oe_ba_n, 1'b1);
    end

    for (genvar g = 0; g < N; g++) begin : g_dir
        regxcvr_store #(.W(W)) u_store (
            .clk (cap_clk[g]),
            .rst (rst),
            .d   (src[g]),
            .q   (held[g])
        );
        regxcvr_path #(.W(W)) u_path (
            .ctl     (ctl[g]),
            .live    (src[g]),
            .stored  (held[g]),
            .data_o  (dout[g]),
            .drive_o (dflag[g])
        );
    end

    assign b_out   = dout[DIR_A2B];
    assign b_drive = dflag[DIR_A2B];
    assign a_out   = dout[DIR_B2A];
    assign a_drive = dflag[DIR_B2A];

    // R5
    live_a2b_chk: assert property (@(posedge clk_ab) disable iff (rst)
        (oe_ab && !sel_ab) |-> (b_out == ~a_in));

    // R6
    stored_a2b_chk: assert property (@(posedge clk_ab) disable iff (rst)
        (oe_ab && sel_ab && !$past(rst)) |-> (b_out == ~$past(a_in)));

    // R7
    stored_b2a_chk: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_ba_n && sel_ba && !$past(rst)) |-> (a_out == ~$past(b_in)));

    // R9
    b_quiet_chk: assert property (@(posedge clk_ab) disable iff (rst)
        !b_drive |-> (b_out == '0));

    // R9
    a_quiet_chk: assert property (@(posedge clk_ba) disable iff (rst)
        !a_drive |-> (a_out == '0));

    // R11
    no_loop_chk: assert property (@(posedge clk_ab) disable iff (rst)
        !(oe_ab && !oe_ba_n && !sel_ab && !sel_ba));

endmodule

// File: tb/regxcvr_bench.sv
module regxcvr_bench;

    logic       clk = 1'b0;
    logic       clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic       sel_ab = 1'b1, sel_ba = 1'b1, oe_ab = 1'b0, oe_ba_n = 1'b1;
    logic [7:0] b_out, a_out;
    logic       b_drive, a_drive;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;
    logic [7:0] m_ab = '0, m_ba = '0;

    always #5 clk = ~clk;

    regxcvr u_regxcvr (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .a_in(a_in), .b_in(b_in), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    // a, b, sel_ab, sel_ba, oe_ab, oe_ba_n, pulse_ab, pulse_ba
    localparam int ROWS = 9;
    localparam logic [21:0] VEC [ROWS] = '{
        {8'h3C, 8'h00, 6'b01_11_00},  // R5 live A to B
        {8'hA5, 8'h5A, 6'b10_00_10},  // R2 R7 capture A, live B to A
        {8'hFF, 8'h0F, 6'b11_11_00},  // R6 stored A to B
        {8'h11, 8'h22, 6'b00_01_11},  // R4 R10 capture both, undriven
        {8'h00, 8'h00, 6'b11_10_00},  // R6 R7 both stored
        {8'hC0, 8'h03, 6'b01_10_01},  // R3 R5 R7
        {8'h81, 8'h7E, 6'b10_10_10},  // R2 R6 R7
        {8'h00, 8'hFF, 6'b11_01_11},  // R4 R10
        {8'h00, 8'hFF, 6'b11_10_00}   // R6 R7
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input bit pab, input bit pba);
        @(negedge clk);
        clk_ab = pab;
        clk_ba = pba;
        #3;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #1;
    endtask

    task automatic check_all();
        logic [7:0] eb, ea;
        eb = oe_ab ? ~(sel_ab ? m_ab : a_in) : 8'h00;
        ea = !oe_ba_n ? ~(sel_ba ? m_ba : b_in) : 8'h00;
        chk(!oe_ab ? "R9 b_out" : (sel_ab ? "R6 b_out" : "R5 b_out"), b_out, eb);
        chk("R7 R9 a_out", a_out, ea);
        chk("R8 b_drive", {7'd0, b_drive}, {7'd0, oe_ab});
        chk("R8 a_drive", {7'd0, a_drive}, {7'd0, ~oe_ba_n});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<5000", cyc);
            finish_run();
        end
    end

    initial begin
        // R1 reset clears both registers
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        rst = 1'b0;
        sel_ab = 1'b1; sel_ba = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b1;
        #1;
        chk("R1 b_out stored after reset", b_out, 8'hFF);
        chk("R9 a_out undriven", a_out, 8'h00);
        oe_ab = 1'b0; oe_ba_n = 1'b0;
        #1;
        chk("R1 a_out stored after reset", a_out, 8'hFF);
        chk("R9 b_out undriven", b_out, 8'h00);

        for (int i = 0; i < ROWS; i++) begin
            {a_in, b_in, sel_ab, sel_ba, oe_ab, oe_ba_n} = VEC[i][21:2];
            // R11 the table never applies the loop combination
            chk("R11 legal row", {7'd0, oe_ab && !oe_ba_n && !sel_ab && !sel_ba}, 8'h00);
            tick(VEC[i][1], VEC[i][0]);
            if (VEC[i][1]) m_ab = a_in;
            if (VEC[i][0]) m_ba = b_in;
            check_all();
        end

        // R1 reset clears only the register whose clock ticks
        rst = 1'b1;
        sel_ab = 1'b1; sel_ba = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b0;
        tick(1'b1, 1'b0);
        chk("R1 A-to-B cleared", b_out, 8'hFF);
        chk("R1 B-to-A kept", a_out, 8'h00);
        tick(1'b0, 1'b1);
        chk("R1 B-to-A cleared", a_out, 8'hFF);
        rst = 1'b0;

        // R4 capture with selects at live and both sides undriven
        a_in = 8'h96; b_in = 8'h69; sel_ab = 1'b0; sel_ba = 1'b0;
        oe_ab = 1'b0; oe_ba_n = 1'b1;
        tick(1'b1, 1'b1);
        chk("R9 b_out undriven", b_out, 8'h00);
        a_in = 8'h00; b_in = 8'h00; sel_ab = 1'b1; sel_ba = 1'b1;
        oe_ab = 1'b1; oe_ba_n = 1'b0;
        #1;
        chk("R4 R10 b_out holds stored", b_out, 8'h69);
        chk("R4 R10 a_out holds stored", a_out, 8'h96);

        finish_run();
    end

endmodule